// File: doc/BRIEF.md
# Conditional Call/Return Unit

This block executes the two control-flow operations of a small virtual machine: a conditional forward call and a conditional return. For each instruction it receives the operation, a 3-bit condition selector, the low 32 bits of a source register, a 32-bit immediate, an 8-bit offset immediate, a 64-bit operand A and the current 16-bit program counter. For each instruction it returns the next program counter, the destination value C, a taken flag and an overflow flag.

A taken call saves the pair (A, return address) on an internal stack and jumps forward. A taken return pops that pair, jumps back and returns A XOR the saved value. Any instruction that is not taken behaves as a move: C = A and the pc moves on to the next 16-byte instruction.

Instructions enter over a valid/ready port and results leave over a valid/ready port. An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented from the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, every result field holds steady and no new instruction is accepted. Results come out in acceptance order, exactly one per instruction.

Top module: `callret_unit`

## Requirements
- R1: A call is taken when the condition picked by `in_cond_sel` holds for `lhs = in_reg_b` and `rhs = in_imm32`, with `d = lhs - rhs` taken modulo 2^32. The encodings are:
  - 0: unsigned lhs <= rhs.
  - 1: unsigned lhs > rhs.
  - 2: bit 31 of d is set.
  - 3: bit 31 of d is clear.
  - 4: the signed subtraction overflows.
  - 5: the signed subtraction does not overflow.
  - 6: signed lhs < rhs.
  - 7: signed lhs >= rhs.
- R2: An instruction that is not taken gives `out_taken=0`, `out_c = in_a` and `out_next_pc = in_pc + 16`.
- R3: A taken call (`in_op=0`) gives `out_taken=1` and `out_c = in_a`. Its next pc is `in_pc + 16*(in_imm8[6:0]+1)`, so bit 7 of `in_imm8` is ignored. It pushes the pair (in_a, in_pc+16).
- R4: A return (`in_op=1`) is taken exactly when the stack holds at least one pair. On an empty stack it acts as in R2.
- R5: A taken return pops the newest pair. It gives `out_next_pc` = the stored return address and `out_c = in_a XOR` the stored value.
- R6: Pairs come back in last-in, first-out order across nested calls.
- R7: The stack holds 64 pairs. A taken call on a full stack discards the oldest pair and keeps the 64 newest, so the next 64 returns are taken and the 65th is not.
- R8: `out_ovf` is 1 only on the result of a taken call issued while the stack was full, and 0 on every other result.
- R9: Each accepted instruction yields one result, in order. While `out_valid && !out_ready`, all result fields hold stable.
- R10: Reset (`rst`, synchronous, active high) empties the stack and clears `out_valid`.
- R11: All pc arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted |
| in_op | input | 1 | 0 = call, 1 = return |
| in_cond_sel | input | 3 | Call condition selector |
| in_reg_b | input | 32 | Low word of the compared register |
| in_imm32 | input | 32 | Compare immediate |
| in_imm8 | input | 8 | Jump offset immediate (bits 6:0 used) |
| in_a | input | 64 | Operand A |
| in_pc | input | 16 | Program counter of the instruction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_next_pc | output | 16 | Next program counter |
| out_c | output | 64 | Destination value |
| out_taken | output | 1 | Call or return was taken |
| out_ovf | output | 1 | Taken call hit a full stack |

## Verification
On every cycle, the assertions check the output handshake (results hold while stalled, and every acceptance produces a result). They also check the stack depth against its bound, that a full stack stays full when it overflows, that a return on an empty stack is never taken, that a return on a non-empty stack pops exactly one pair, and that the reset state is correct. Only the bench scenarios can show that the data is right: the truth table of all eight conditions at signed and unsigned boundaries, the jump and return targets including wraparound, the XOR of saved values in last-in-first-out order, and the choice of which pair an overflow drops.

// File: rtl/callret_pkg.sv
package callret_pkg;
  typedef enum logic {
    OP_CALL = 1'b0,
    OP_RET  = 1'b1
  } cr_op_e;
endpackage

// File: rtl/callret_cond.sv
module callret_cond #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic [2:0]   sel,
  output logic         hit
);
  logic [W:0] diff;
  logic borrow, neg, zero, sovf, slt;

  // One subtractor feeds every flag.
  assign diff   = {1'b0, lhs} - {1'b0, rhs};
  assign borrow = diff[W];
  assign neg    = diff[W-1];
  assign zero   = (diff[W-1:0] == '0);
  assign sovf   = (lhs[W-1] ^ rhs[W-1]) & (neg ^ lhs[W-1]);
  assign slt    = neg ^ sovf;

  always_comb begin
    unique case (sel)
      3'd0: hit = borrow | zero;
      3'd1: hit = ~borrow & ~zero;
      3'd2: hit = neg;
      3'd3: hit = ~neg;
      3'd4: hit = sovf;
      3'd5: hit = ~sovf;
      3'd6: hit = slt;
      default: hit = ~slt;
    endcase
  end
endmodule

// File: rtl/callret_stack.sv
module callret_stack #(
  parameter int DEPTH = 64,
  parameter int VAL_W = 64,
  parameter int ADR_W = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [VAL_W-1:0] push_val,
  input  logic [ADR_W-1:0] push_ret,
  output logic [VAL_W-1:0] peek_val,
  output logic [ADR_W-1:0] peek_ret,
  output logic [CNT_W-1:0] depth,
  output logic             empty,
  output logic             full
);
  logic [VAL_W-1:0] val_mem [DEPTH];
  logic [ADR_W-1:0] ret_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, top_ptr, wr_nxt;

  // Ring buffer: a push on a full stack overwrites the oldest slot.
  assign wr_nxt  = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
  assign top_ptr = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - PTR_W'(1);
  assign empty   = (depth == '0);
  assign full    = (depth == CNT_W'(DEPTH));
  assign peek_val = val_mem[top_ptr];
  assign peek_ret = ret_mem[top_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      val_mem[wr_ptr] <= push_val;
      ret_mem[wr_ptr] <= push_ret;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      depth  <= '0;
    end else if (push) begin
      wr_ptr <= wr_nxt;
      if (!full) depth <= depth + CNT_W'(1);
    end else if (pop && !empty) begin
      wr_ptr <= top_ptr;
      depth  <= depth - CNT_W'(1);
    end
  end
endmodule

// File: rtl/callret_unit.sv
module callret_unit
  import callret_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int DATA_W     = 64,
  parameter int CMP_W      = 32,
  parameter int DEPTH      = 64,
  parameter int INSN_BYTES = 16,
  localparam int OFS_SH    = $clog2(INSN_BYTES),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [2:0]        in_cond_sel,
  input  logic [CMP_W-1:0]  in_reg_b,
  input  logic [CMP_W-1:0]  in_imm32,
  input  logic [7:0]        in_imm8,
  input  logic [DATA_W-1:0] in_a,
  input  logic [PC_W-1:0]   in_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PC_W-1:0]   out_next_pc,
  output logic [DATA_W-1:0] out_c,
  output logic              out_taken,
  output logic              out_ovf
);
  cr_op_e op;
  logic fire, cond_hit, call_take, ret_take;
  logic push, pop;
  logic [PC_W-1:0] seq_pc, hop, jump_pc;
  logic [PC_W-1:0] nxt_pc;
  logic [DATA_W-1:0] nxt_c;
  logic [DATA_W-1:0] stk_val;
  logic [PC_W-1:0] stk_ret;
  logic [CNT_W-1:0] stk_depth;
  logic stk_empty, stk_full;
  logic unused_imm8_msb;

  assign op              = cr_op_e'(in_op);
  assign in_ready        = !out_valid || out_ready;
  assign fire            = in_valid && in_ready;
  assign unused_imm8_msb = in_imm8[7];

  callret_cond #(.W(CMP_W)) u_cond (
    .lhs (in_reg_b),
    .rhs (in_imm32),
    .sel (in_cond_sel),
    .hit (cond_hit)
  );

  assign call_take = (op == OP_CALL) && cond_hit;
  assign ret_take  = (op == OP_RET) && !stk_empty;

  assign seq_pc  = in_pc + PC_W'(INSN_BYTES);
  assign hop     = (PC_W'(in_imm8[6:0]) + PC_W'(1)) << OFS_SH;
  assign jump_pc = in_pc + hop;

  assign push = fire && call_take;
  assign pop  = fire && ret_take;

  callret_stack #(
    .DEPTH (DEPTH),
    .VAL_W (DATA_W),
    .ADR_W (PC_W)
  ) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .push_val (in_a),
    .push_ret (seq_pc),
    .peek_val (stk_val),
    .peek_ret (stk_ret),
    .depth    (stk_depth),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  always_comb begin
    nxt_pc = seq_pc;
    nxt_c  = in_a;
    if (call_take) begin
      nxt_pc = jump_pc;
    end else if (ret_take) begin
      nxt_pc = stk_ret;
      nxt_c  = in_a ^ stk_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_next_pc <= '0;
      out_c       <= '0;
      out_taken   <= 1'b0;
      out_ovf     <= 1'b0;
    end else if (fire) begin
      out_valid   <= 1'b1;
      out_next_pc <= nxt_pc;
      out_c       <= nxt_c;
      out_taken   <= call_take || ret_take;
      out_ovf     <= call_take && stk_full;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/callret_chk.sv
module callret_chk #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PC_W-1:0]   out_next_pc,
  input logic [DATA_W-1:0] out_c,
  input logic              out_taken,
  input logic              out_ovf,
  input logic [CNT_W-1:0]  depth
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) && $stable(out_c)
                                && $stable(out_taken) && $stable(out_ovf));

  // R9
  accept_result_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(DEPTH));

  // R7
  full_stays_full_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !in_op && depth == CNT_W'(DEPTH) |=> depth == CNT_W'(DEPTH));

  // R8
  ovf_only_taken_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ovf |-> out_taken);

  // R4
  empty_ret_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_op && depth == '0 |=> !out_taken && depth == '0);

  // R5
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_op && depth != '0 |=> out_taken && depth == $past(depth) - CNT_W'(1));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !out_valid && depth == '0);
endmodule

bind callret_unit callret_chk #(
  .PC_W   (PC_W),
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_next_pc (out_next_pc),
  .out_c       (out_c),
  .out_taken   (out_taken),
  .out_ovf     (out_ovf),
  .depth       (stk_depth)
);

// File: tb/tb_callret_unit.sv
module tb_callret_unit;
  localparam int CAP = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_op = 1'b0, out_ready = 1'b0;
  logic [2:0] in_cond_sel = '0;
  logic [31:0] in_reg_b = '0, in_imm32 = '0;
  logic [7:0] in_imm8 = '0;
  logic [63:0] in_a = '0;
  logic [15:0] in_pc = '0;
  logic in_ready, out_valid, out_taken, out_ovf;
  logic [15:0] out_next_pc;
  logic [63:0] out_c;

  always #4 clk = ~clk;

  callret_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_cond_sel(in_cond_sel), .in_reg_b(in_reg_b), .in_imm32(in_imm32), .in_imm8(in_imm8),
    .in_a(in_a), .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready),
    .out_next_pc(out_next_pc), .out_c(out_c), .out_taken(out_taken), .out_ovf(out_ovf)
  );

  typedef struct {
    logic [15:0] pc;
    logic [63:0] c;
    logic taken;
    logic ovf;
    string req;
  } exp_t;

  exp_t expq[$];
  logic [63:0] m_val[$];
  logic [15:0] m_ret[$];
  int checks = 0, errors = 0;
  bit driving_done = 0, random_ready = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit cond_model(int sel, logic [31:0] r, logic [31:0] i);
    longint ur = longint'({32'b0, r});
    longint ui = longint'({32'b0, i});
    longint sr = longint'(signed'(r));
    longint si = longint'(signed'(i));
    longint d  = sr - si;
    logic [31:0] w = r - i;
    case (sel)
      0: return ur <= ui;
      1: return ur > ui;
      2: return w[31];
      3: return !w[31];
      4: return (d > 64'sd2147483647) || (d < -64'sd2147483648);
      5: return !((d > 64'sd2147483647) || (d < -64'sd2147483648));
      6: return sr < si;
      default: return sr >= si;
    endcase
  endfunction

  task automatic send(bit op, int sel, logic [31:0] r, logic [31:0] i, logic [7:0] i8,
                      logic [63:0] a, logic [15:0] pc, string req);
    exp_t e;
    e.req = req; e.c = a; e.ovf = 0; e.taken = 0; e.pc = pc + 16'd16;
    if (!op) begin
      if (cond_model(sel, r, i)) begin
        e.taken = 1;
        e.pc = pc + 16'(16 * (int'(i8[6:0]) + 1));
        if (m_val.size() == CAP) begin
          e.ovf = 1;
          void'(m_val.pop_front());
          void'(m_ret.pop_front());
        end
        m_val.push_back(a);
        m_ret.push_back(pc + 16'd16);
      end
    end else if (m_val.size() > 0) begin
      e.taken = 1;
      e.pc = m_ret.pop_back();
      e.c = a ^ m_val.pop_back();
    end
    expq.push_back(e);
    @(negedge clk);
    in_valid = 1; in_op = op; in_cond_sel = 3'(sel); in_reg_b = r; in_imm32 = i;
    in_imm8 = i8; in_a = a; in_pc = pc;
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
  endtask

  // Monitor: drives out_ready, pops and compares results, checks stall stability.
  initial begin : monitor
    logic held = 0;
    logic [15:0] h_pc; logic [63:0] h_c; logic h_t, h_o;
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      out_ready = random_ready ? ($urandom_range(0, 3) != 0) : (n % 5 != 3);
      #2;
      if (held && out_valid) begin
        chk(out_next_pc == h_pc && out_c == h_c && out_taken == h_t && out_ovf == h_o,
            "R9", "stall hold", out_c, h_c);
      end
      held = 0;
      if (out_valid && out_ready) begin
        exp_t e;
        if (expq.size() == 0) begin
          chk(0, "R9", "unexpected result", out_c, 0);
        end else begin
          e = expq.pop_front();
          chk(out_taken == e.taken, e.req, "taken", out_taken, e.taken);
          chk(out_next_pc == e.pc, e.req, "next_pc", out_next_pc, e.pc);
          chk(out_c == e.c, e.req, "C", out_c, e.c);
          chk(out_ovf == e.ovf, (e.ovf ? "R7" : "R8"), "ovf", out_ovf, e.ovf);
        end
      end else if (out_valid) begin
        held = 1; h_pc = out_next_pc; h_c = out_c; h_t = out_taken; h_o = out_ovf;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    logic [31:0] pr [7] = '{32'd5, 32'd3, 32'd7, 32'h8000_0000, 32'h7fff_ffff, 32'd0, 32'hffff_ffff};
    logic [31:0] pi [7] = '{32'd5, 32'd7, 32'd3, 32'd1, 32'hffff_ffff, 32'h8000_0000, 32'd0};
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state visible at the ports
    chk(out_valid == 0, "R10", "out_valid in reset", out_valid, 0);
    @(negedge clk); rst = 0;
    #1;
    chk(in_ready == 1, "R10", "in_ready after reset", in_ready, 1);

    // R1/R3/R5: every condition against boundary operand pairs; taken calls are returned
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 7; k++) begin
        logic [15:0] pc = 16'(s * 512 + k * 64);
        logic [63:0] a = {32'(s), 32'(k)} ^ 64'h5a5a_0000_1234_0000;
        send(0, s, pr[k], pi[k], 8'(k * 3), a, pc, "R1");
        if (cond_model(s, pr[k], pi[k]))
          send(1, 0, 0, 0, 0, 64'h0f0f_0f0f_0f0f_0f0f, pc + 16'd800, "R5");
      end
    end

    // R4/R2: return on empty stack acts as a move
    send(1, 0, 0, 0, 0, 64'hdead_beef_0000_0001, 16'h0100, "R4");

    // R3/R11: bit 7 of imm8 ignored, jump and return address wrap
    send(0, 0, 0, 0, 8'hff, 64'h1111, 16'hfff0, "R11");
    send(1, 0, 0, 0, 0, 64'h2222, 16'h0020, "R11");

    // R6: nested calls return in reverse order
    for (int k = 0; k < 3; k++)
      send(0, 0, 0, 0, 8'(k), 64'h100 << k, 16'(k * 32), "R6");
    random_ready = 1;
    for (int k = 0; k < 3; k++)
      send(1, 0, 0, 0, 0, 64'hffff, 16'h4000, "R6");

    // R7/R8: fill past capacity, then drain one more than capacity
    for (int k = 0; k < CAP + 1; k++)
      send(0, 7, 32'd9, 32'd9, 8'd0, 64'(k) * 64'h1_0001, 16'(k * 16), "R7");
    for (int k = 0; k < CAP + 1; k++)
      send(1, 0, 0, 0, 0, 64'habc0 + 64'(k), 16'h8000, "R7");

    @(negedge clk); in_valid = 0;
    random_ready = 0;
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R9", "pending results", 64'(expq.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule